// File: doc/BRIEF.md
# Fibre Channel Port Link State Machine

This block follows the link-level condition of a single fixed-rate 8G Fibre Channel port. The receive path hands it one decoded transmission word per valid cycle, classified as Idle, LR, LRR, NOS, OLS, a start-of-frame delimiter or anything else. It also receives a loss-of-sync/signal flag and a local request to reset the link. From these it steps through a nine-state recovery and offline machine. It tells the transmit path which primitive sequence or Idle to send.

A received primitive sequence counts only once a run of consecutive identical words has been seen. The run length defaults to three. The block exposes a numeric state code, a port-active flag for a front-panel LED, a counter of entries into the Active state and a counter of frames received while Active. The state code and both counters can be read as 32-bit words through a small select-based read port. There is no speed negotiation, and line coding and frame contents are handled elsewhere.

Top module: `fc_port_link_fsm`

## Requirements
- R1: While rst_n is low and after its release, the machine is in OL1 (code 6), tx_seq is OLS, port_active is 0 and both counters read 0.
- R2: A primitive sequence is recognised once MATCH_LEN (default 3) consecutive valid words carry the same sequence code: Idle=1, LR=2, LRR=3, NOS=4 or OLS=5. Any other valid word restarts the run. Cycles with rx_valid low neither extend nor break the run.
- R3: The bring-up chain runs as follows. OL1 with OLS recognised goes to OL2, which sends LR. OL2 with LR goes to LR2, which sends LRR. LR2 with LRR goes to LR3, which sends Idle. LR3 with Idle goes to Active, which sends Idle. tx_seq encodes Idle=0, LR=1, LRR=2, NOS=3, OLS=4.
- R4: rx_sync_lost high at a clock edge moves the machine to LF2, from any state; LF2 sends NOS. LF2 with NOS recognised goes to LF1, which sends OLS. LF1 with OLS goes to OL2.
- R5: In Active, LR recognised goes to LR2. Without a recognised sequence, link_reset_req goes to LR1, which sends LR. LR1 with LRR recognised goes to LR3.
- R6: OL1 with NOS recognised goes to OL3, which sends NOS. OL3 with OLS recognised goes to OL2.
- R7: The state code is fixed: Active=0, LR1=1, LR2=2, LR3=3, LF1=4, LF2=5, OL1=6, OL2=7, OL3=8. It never exceeds 8.
- R8: port_active is 1 exactly while the state code is 0.
- R9: The Active-entry counter adds one on each transition into Active from another state, and holds otherwise.
- R10: The frame counter adds one for each valid start-of-frame word (rx_code 6) received while in Active. Such words in any other state leave it unchanged.
- R11: rd_data is combinational from rd_sel: 0 gives the zero-extended state code, 1 gives the Active-entry count, 2 gives the frame count and 3 gives zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | A decoded receive word is present this cycle |
| rx_code | input | 3 | Class of the received word (0 other, 1 Idle, 2 LR, 3 LRR, 4 NOS, 5 OLS, 6 start of frame, 7 other) |
| rx_sync_lost | input | 1 | Receiver has lost word sync or signal |
| link_reset_req | input | 1 | Local request to start a link reset |
| tx_seq | output | 3 | Sequence the transmitter must send (0 Idle, 1 LR, 2 LRR, 3 NOS, 4 OLS) |
| state_code | output | 4 | Current numeric state |
| port_active | output | 1 | High while in Active, drives the LED |
| rd_sel | input | 2 | Read register select |
| rd_data | output | 32 | Selected register value |

## Verification
The assertions assume that rx_code is meaningful only when rx_valid is high, and that link_reset_req matters only while Active. They also assume every input is synchronous to clk, and they draw no conclusion from rx_code on cycles without a valid word. The stimulus changes inputs only at falling edges and sends words in bursts followed by idle cycles. It raises rx_sync_lost for single cycles and pulses link_reset_req only after the port has been brought into Active. Stale recognition is harmless because, for every target state, the sequence that led into it is one that state ignores.

// File: rtl/fcps_pkg.sv
package fcps_pkg;

   // Numeric state codes; values are visible to software
   typedef enum logic [3:0] {
      ST_ACTIVE = 4'd0,
      ST_LR1    = 4'd1,
      ST_LR2    = 4'd2,
      ST_LR3    = 4'd3,
      ST_LF1    = 4'd4,
      ST_LF2    = 4'd5,
      ST_OL1    = 4'd6,
      ST_OL2    = 4'd7,
      ST_OL3    = 4'd8
   } port_state_e;

   // Receive word classes
   typedef enum logic [2:0] {
      RX_OTHER = 3'd0,
      RX_IDLE  = 3'd1,
      RX_LR    = 3'd2,
      RX_LRR   = 3'd3,
      RX_NOS   = 3'd4,
      RX_OLS   = 3'd5,
      RX_SOF   = 3'd6,
      RX_RSVD  = 3'd7
   } rx_word_e;

   // Transmit sequence selection
   typedef enum logic [2:0] {
      TX_IDLE = 3'd0,
      TX_LR   = 3'd1,
      TX_LRR  = 3'd2,
      TX_NOS  = 3'd3,
      TX_OLS  = 3'd4
   } tx_seq_e;

   localparam int unsigned REG_W = 32;

   function automatic logic is_sequence(input logic [2:0] c);
      return (c >= 3'd1) && (c <= 3'd5);
   endfunction

endpackage

// File: rtl/fcps_seq_detect.sv
module fcps_seq_detect
   import fcps_pkg::*;
#(
   parameter int unsigned MATCH_LEN = 3
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       rx_valid,
   input  logic [2:0] rx_code,
   input  logic       sync_lost,
   output logic       det_valid,
   output logic [2:0] det_code
);
   localparam int unsigned RUN_W = $clog2(MATCH_LEN + 1);
   localparam logic [RUN_W-1:0] RUN_FULL = RUN_W'(MATCH_LEN);

   generate
      if (MATCH_LEN < 2 || MATCH_LEN > 15) begin : g_bad_len
         $error("fcps_seq_detect: MATCH_LEN must lie in 2..15");
      end
   endgenerate

   logic [2:0]       run_code;
   logic [RUN_W-1:0] run_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_code <= 3'd0;
         run_cnt  <= '0;
      end else if (sync_lost) begin
         run_cnt  <= '0;
      end else if (rx_valid) begin
         if (!is_sequence(rx_code)) begin
            run_code <= rx_code;
            run_cnt  <= '0;
         end else if (rx_code == run_code && run_cnt != '0) begin
            if (run_cnt != RUN_FULL)
               run_cnt <= run_cnt + 1'b1;
         end else begin
            run_code <= rx_code;
            run_cnt  <= RUN_W'(1);
         end
      end
   end

   assign det_valid = (run_cnt == RUN_FULL);
   assign det_code  = run_code;

   // R2
   recog_needs_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(det_valid) |-> $past(rx_valid));

   // R2
   recog_is_sequence_chk: assert property (@(posedge clk) disable iff (!rst_n)
      det_valid |-> is_sequence(det_code));

endmodule

// File: rtl/fcps_event_ctr.sv
module fcps_event_ctr #(
   parameter int unsigned WIDTH    = 32,
   parameter bit          SATURATE = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bump,
   output logic [WIDTH-1:0] count
);
   generate
      if (WIDTH < 1 || WIDTH > 32) begin : g_bad_w
         $error("fcps_event_ctr: WIDTH must lie in 1..32");
      end
   endgenerate

   logic [WIDTH-1:0] cnt_q;
   logic             step;

   generate
      if (SATURATE) begin : g_sat
         assign step = bump && (cnt_q != {WIDTH{1'b1}});
      end else begin : g_wrap
         assign step = bump;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt_q <= '0;
      else if (step) cnt_q <= cnt_q + 1'b1;
   end

   assign count = cnt_q;

   // R9 R10
   hold_without_bump_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(bump) |-> $stable(cnt_q));

endmodule

// File: rtl/fcps_state_core.sv
module fcps_state_core
   import fcps_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        sync_lost,
   input  logic        reset_req,
   input  logic        det_valid,
   input  logic [2:0]  det_code,
   output port_state_e state,
   output logic [2:0]  tx_seq,
   output logic        enter_active
);
   port_state_e st_q, st_nxt;

   function automatic logic seen(input logic v, input logic [2:0] c, input rx_word_e w);
      return v && (c == 3'(w));
   endfunction

   always_comb begin
      st_nxt = st_q;
      if (sync_lost) begin
         st_nxt = ST_LF2;
      end else begin
         unique case (st_q)
            ST_ACTIVE: begin
               if (seen(det_valid, det_code, RX_LR))       st_nxt = ST_LR2;
               else if (seen(det_valid, det_code, RX_OLS)) st_nxt = ST_OL2;
               else if (seen(det_valid, det_code, RX_NOS)) st_nxt = ST_LF1;
               else if (reset_req)                         st_nxt = ST_LR1;
            end
            ST_LR1: begin
               if (seen(det_valid, det_code, RX_LRR))      st_nxt = ST_LR3;
               else if (seen(det_valid, det_code, RX_LR))  st_nxt = ST_LR2;
               else if (seen(det_valid, det_code, RX_OLS)) st_nxt = ST_OL2;
               else if (seen(det_valid, det_code, RX_NOS)) st_nxt = ST_LF1;
            end
            ST_LR2: begin
               if (seen(det_valid, det_code, RX_LRR))      st_nxt = ST_LR3;
               else if (seen(det_valid, det_code, RX_OLS)) st_nxt = ST_OL2;
               else if (seen(det_valid, det_code, RX_NOS)) st_nxt = ST_LF1;
            end
            ST_LR3: begin
               if (seen(det_valid, det_code, RX_IDLE))     st_nxt = ST_ACTIVE;
               else if (seen(det_valid, det_code, RX_OLS)) st_nxt = ST_OL2;
               else if (seen(det_valid, det_code, RX_NOS)) st_nxt = ST_LF1;
            end
            ST_LF2: if (seen(det_valid, det_code, RX_NOS)) st_nxt = ST_LF1;
            ST_LF1: if (seen(det_valid, det_code, RX_OLS)) st_nxt = ST_OL2;
            ST_OL1: begin
               if (seen(det_valid, det_code, RX_OLS))      st_nxt = ST_OL2;
               else if (seen(det_valid, det_code, RX_NOS)) st_nxt = ST_OL3;
            end
            ST_OL2: begin
               if (seen(det_valid, det_code, RX_LR))       st_nxt = ST_LR2;
               else if (seen(det_valid, det_code, RX_NOS)) st_nxt = ST_LF1;
            end
            ST_OL3: if (seen(det_valid, det_code, RX_OLS)) st_nxt = ST_OL2;
            default: st_nxt = ST_OL1;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= ST_OL1;
      else        st_q <= st_nxt;
   end

   always_comb begin
      unique case (st_q)
         ST_ACTIVE, ST_LR3:        tx_seq = 3'(TX_IDLE);
         ST_LR1, ST_OL2:           tx_seq = 3'(TX_LR);
         ST_LR2:                   tx_seq = 3'(TX_LRR);
         ST_LF2, ST_OL3:           tx_seq = 3'(TX_NOS);
         ST_LF1, ST_OL1:           tx_seq = 3'(TX_OLS);
         default:                  tx_seq = 3'(TX_OLS);
      endcase
   end

   assign state        = st_q;
   assign enter_active = (st_nxt == ST_ACTIVE) && (st_q != ST_ACTIVE);

   // R4
   sync_loss_to_lf2_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sync_lost |=> (st_q == ST_LF2));

   // R7
   legal_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      st_q <= ST_OL3);

   // R3
   active_only_from_lr3_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(st_q == ST_ACTIVE) |-> $past(st_q) == ST_LR3);

endmodule

// File: rtl/fc_port_link_fsm.sv
module fc_port_link_fsm
   import fcps_pkg::*;
#(
   parameter int unsigned MATCH_LEN    = 3,
   parameter int unsigned CNT_W        = 32,
   parameter bit          CNT_SATURATE = 1'b0
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        rx_valid,
   input  logic [2:0]  rx_code,
   input  logic        rx_sync_lost,
   input  logic        link_reset_req,
   output logic [2:0]  tx_seq,
   output logic [3:0]  state_code,
   output logic        port_active,
   input  logic [1:0]  rd_sel,
   output logic [31:0] rd_data
);
   generate
      if (CNT_W > REG_W) begin : g_bad_cnt
         $error("fc_port_link_fsm: CNT_W wider than the read word");
      end
   endgenerate

   logic             det_valid;
   logic [2:0]       det_code;
   port_state_e      state;
   logic             enter_active;
   logic             frame_seen;
   logic [CNT_W-1:0] active_entries;
   logic [CNT_W-1:0] frames_rx;

   fcps_seq_detect #(.MATCH_LEN(MATCH_LEN)) u_detect (
      .clk       (clk),
      .rst_n     (rst_n),
      .rx_valid  (rx_valid),
      .rx_code   (rx_code),
      .sync_lost (rx_sync_lost),
      .det_valid (det_valid),
      .det_code  (det_code)
   );

   fcps_state_core u_core (
      .clk          (clk),
      .rst_n        (rst_n),
      .sync_lost    (rx_sync_lost),
      .reset_req    (link_reset_req),
      .det_valid    (det_valid),
      .det_code     (det_code),
      .state        (state),
      .tx_seq       (tx_seq),
      .enter_active (enter_active)
   );

   assign frame_seen = rx_valid && (rx_code == 3'(RX_SOF)) && (state == ST_ACTIVE);

   fcps_event_ctr #(.WIDTH(CNT_W), .SATURATE(CNT_SATURATE)) u_entry_ctr (
      .clk   (clk),
      .rst_n (rst_n),
      .bump  (enter_active),
      .count (active_entries)
   );

   fcps_event_ctr #(.WIDTH(CNT_W), .SATURATE(CNT_SATURATE)) u_frame_ctr (
      .clk   (clk),
      .rst_n (rst_n),
      .bump  (frame_seen),
      .count (frames_rx)
   );

   assign state_code  = 4'(state);
   assign port_active = (state == ST_ACTIVE);

   always_comb begin
      unique case (rd_sel)
         2'd0:    rd_data = REG_W'(state_code);
         2'd1:    rd_data = REG_W'(active_entries);
         2'd2:    rd_data = REG_W'(frames_rx);
         default: rd_data = '0;
      endcase
   end

   // R9
   entry_count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(port_active) |-> active_entries == $past(active_entries) + 1'b1 || CNT_SATURATE);

   // R10
   no_frame_outside_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(port_active) |-> $stable(frames_rx));

endmodule

// File: tb/tb_fc_port_link_fsm.sv
module tb_fc_port_link_fsm;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rx_valid = 1'b0;
   logic [2:0]  rx_code = 3'd0;
   logic        rx_sync_lost = 1'b0;
   logic        link_reset_req = 1'b0;
   logic [2:0]  tx_seq;
   logic [3:0]  state_code;
   logic        port_active;
   logic [1:0]  rd_sel = 2'd0;
   logic [31:0] rd_data;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   localparam logic [2:0] C_OTHER = 3'd0, C_IDLE = 3'd1, C_LR = 3'd2, C_LRR = 3'd3,
                          C_NOS = 3'd4, C_OLS = 3'd5, C_SOF = 3'd6;
   localparam logic [2:0] T_IDLE = 3'd0, T_LR = 3'd1, T_LRR = 3'd2, T_NOS = 3'd3, T_OLS = 3'd4;

   always #5 clk = ~clk;

   fc_port_link_fsm dut (
      .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_code(rx_code),
      .rx_sync_lost(rx_sync_lost), .link_reset_req(link_reset_req),
      .tx_seq(tx_seq), .state_code(state_code), .port_active(port_active),
      .rd_sel(rd_sel), .rd_data(rd_data)
   );

   task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic check_state(input string req, input logic [3:0] st, input logic [2:0] tx);
      check(req, "state", 32'(state_code), 32'(st));
      check(req, "tx_seq", 32'(tx_seq), 32'(tx));
      check(req, "port_active", 32'(port_active), 32'(st == 4'd0));
   endtask

   task automatic read_reg(input logic [1:0] sel, output logic [31:0] val);
      @(negedge clk);
      rd_sel = sel;
      #1 val = rd_data;
   endtask

   task automatic send(input logic [2:0] code, input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         rx_valid = 1'b1;
         rx_code  = code;
      end
      @(negedge clk);
      rx_valid = 1'b0;
      rx_code  = C_OTHER;
      @(negedge clk);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      rx_valid = 1'b0;
      rx_sync_lost = 1'b0;
      link_reset_req = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic bring_up();
      send(C_OLS, 3);
      send(C_LR, 3);
      send(C_LRR, 3);
      send(C_IDLE, 3);
   endtask

   task automatic t_reset();
      logic [31:0] v;
      do_reset();
      check_state("R1", 4'd6, T_OLS);
      read_reg(2'd1, v); check("R1", "entries", v, 0);
      read_reg(2'd2, v); check("R1", "frames", v, 0);
      read_reg(2'd0, v); check("R11", "state word", v, 6);
      read_reg(2'd3, v); check("R11", "unused word", v, 0);
   endtask

   task automatic t_bring_up();
      logic [31:0] v;
      do_reset();
      send(C_SOF, 2);
      read_reg(2'd2, v); check("R10", "frames outside Active", v, 0);
      send(C_OLS, 3); check_state("R3", 4'd7, T_LR);
      send(C_LR, 3);  check_state("R3", 4'd2, T_LRR);
      send(C_LRR, 3); check_state("R3", 4'd3, T_IDLE);
      send(C_IDLE, 3); check_state("R8", 4'd0, T_IDLE);
      read_reg(2'd1, v); check("R9", "entries after bring-up", v, 1);
      send(C_SOF, 5);
      read_reg(2'd2, v); check("R10", "frames in Active", v, 5);
      read_reg(2'd1, v); check("R9", "entries unchanged by frames", v, 1);
   endtask

   task automatic t_match_rules();
      do_reset();
      send(C_OLS, 2);
      send(C_NOS, 1);
      send(C_OLS, 2);
      check_state("R2", 4'd6, T_OLS);
      send(C_OLS, 1);
      check_state("R2", 4'd7, T_LR);
      do_reset();
      send(C_OLS, 1); send(C_OLS, 1); send(C_OLS, 1);
      check_state("R2", 4'd7, T_LR);
      do_reset();
      send(C_OLS, 2); send(C_SOF, 1); send(C_OLS, 2);
      check_state("R2", 4'd6, T_OLS);
   endtask

   task automatic t_local_reset();
      logic [31:0] v;
      do_reset();
      bring_up();
      @(negedge clk); link_reset_req = 1'b1;
      @(negedge clk); link_reset_req = 1'b0;
      check_state("R5", 4'd1, T_LR);
      send(C_LRR, 3); check_state("R5", 4'd3, T_IDLE);
      send(C_IDLE, 3); check_state("R3", 4'd0, T_IDLE);
      read_reg(2'd1, v); check("R9", "entries after local reset", v, 2);
      send(C_LR, 3); check_state("R5", 4'd2, T_LRR);
   endtask

   task automatic t_sync_loss();
      do_reset();
      bring_up();
      @(negedge clk); rx_sync_lost = 1'b1;
      @(negedge clk); rx_sync_lost = 1'b0;
      check_state("R4", 4'd5, T_NOS);
      send(C_NOS, 3); check_state("R4", 4'd4, T_OLS);
      send(C_OLS, 3); check_state("R4", 4'd7, T_LR);
   endtask

   task automatic t_offline_wait();
      do_reset();
      send(C_NOS, 3); check_state("R6", 4'd8, T_NOS);
      send(C_OLS, 3); check_state("R6", 4'd7, T_LR);
   endtask

   initial begin
      t_reset();
      t_bring_up();
      t_match_rules();
      t_local_reset();
      t_sync_loss();
      t_offline_wait();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            if (!done) begin
               checks++;
               errors++;
               $display("FAIL watchdog: actual=timeout expected=completion");
            end
         end
      join_any
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule